// File: doc/BRIEF.md
# Dual-Engine Security Access Router

This block sits in front of two crypto engine cores and decides, request by request, whether a requester may proceed and where the request goes. Each core holds one security bit. These bits form a small configuration word. Every request carries the requester's world, which is secure or non-secure. A request either targets one core's configuration-register interface or targets memory. Memory requests also carry a region-security flag that an upstream region lookup supplies.

The two security bits select one of four modes:
- **Split mode.** Core 1 is secure and core 0 is non-secure. Each world is pinned to one core.
- **All-secure mode.** Both cores are secure. Secure traffic to secure regions is shared between both cores.
- **All-open mode.** Both cores are non-secure. Everything is accepted and shared between both cores.
- **Forbidden mode.** Core 0 is secure and core 1 is non-secure. This combination raises a sticky error and locks the block out.

A denied request finishes in the same cycle with an error flag and never reaches a core. An accepted memory request waits until its core reports free. When the request is shared, it goes to the first free core, and ties rotate. Configuration writes that arrive while a request is presented are held back until the request input goes idle.

Top module: `sec_router`

## Requirements
- R1: After reset, both security bits are 0 (all-open mode) and `config_error` is 0. The first tie between two free cores goes to core 0.
- R2: Register accesses in split mode (`cfg_wdata`=2'b10, where bit 0 is core 0 secure and bit 1 is core 1 secure) are decided as follows. A non-secure access to core 1's registers (`req_reg_core`=1) is denied. A non-secure access to core 0's registers is accepted. Secure register accesses are accepted.
- R3: In split mode, a non-secure memory request (`req_world_sec`=0) to a non-secure region (`req_region_sec`=0) is started on core 0. A non-secure memory request to a secure region is denied.
- R4: In split mode, a secure memory request to a secure region is started on core 1. A secure memory request to a non-secure region is started on core 0.
- R5: In all-secure mode (2'b11), every non-secure request is denied, whether it targets registers or memory. Secure register accesses are accepted.
- R6: In all-secure mode, a secure memory request to a secure region is accepted on a free core. A secure memory request to a non-secure region is denied.
- R7: In all-open mode (2'b00), every register and memory request from either world is accepted. Memory requests go to a free core.
- R8: Loading the forbidden word 2'b01 sets `config_error`, and every request is then denied. Loading any other word clears `config_error`.
- R9: For a shared memory request, the single free core is chosen when only one core is free. When both cores are free, the preferred core is chosen. After each shared grant, the preference moves to the other core.
- R10: A denied request has `req_ready`=1 and `req_err`=1 in the cycle it is presented. In that cycle, no `core_start` or `reg_sel` bit is set.
- R11: An accepted memory request holds `req_ready`=0 while its chosen core is busy. A pinned request never moves to the other core. A start is only issued to a core whose `core_free` bit is 1.
- R12: A configuration write is applied at the clock edge where `req_valid` is 0. A write seen while `req_valid` is 1 is held and applied at the first later edge with `req_valid` at 0. A newer write replaces a held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the security word |
| cfg_wdata | input | 2 | Security word: bit 0 is core 0 secure, bit 1 is core 1 secure |
| req_valid | input | 1 | A request is presented |
| req_is_reg | input | 1 | 1 = register-interface access, 0 = memory access |
| req_reg_core | input | 1 | Core whose register interface is targeted |
| req_world_sec | input | 1 | Requester world: 1 = secure |
| req_region_sec | input | 1 | Target region is secure (memory only) |
| req_ready | output | 1 | Request completes this cycle |
| req_err | output | 1 | Completing request is denied |
| core_free | input | 2 | Per-core free indication |
| core_start | output | 2 | Per-core start pulse for an accepted memory request |
| reg_sel | output | 2 | Per-core register-interface select for an accepted access |
| config_error | output | 1 | Sticky flag for the forbidden security word |

## Verification
The hardest situation to reach is a configuration write that lands while a request is held waiting on a busy core. The held write must not change the verdict of that waiting request, and it must take effect only after the request goes idle. The bench creates this situation by keeping `core_free` low under a pinned memory request for several cycles and pulsing `cfg_we` meanwhile. It then releases the core, drops `req_valid` and probes the new mode. A similar long wait with both cores busy is used before a shared grant, to confirm that the rotating preference still starts from the expected core.

// File: rtl/sr_pkg.sv
// Shared types for the security access router.
// Assumes exactly two engine cores; the mode encoding follows the
// per-core security bits (bit 0 = core 0, bit 1 = core 1).
package sr_pkg;
    localparam int NCORE  = 2;
    localparam int CIDX_W = $clog2(NCORE);

    typedef enum logic [NCORE-1:0] {
        MODE_OPEN   = 2'b00,
        MODE_FORBID = 2'b01,
        MODE_SPLIT  = 2'b10,
        MODE_ALLSEC = 2'b11
    } sec_mode_t;

    typedef struct packed {
        logic              deny;
        logic              share;
        logic [CIDX_W-1:0] pin_core;
    } verdict_t;
endpackage

// File: rtl/sr_cfg_shadow.sv
// Holds the active security word and the sticky forbidden-config flag.
// Writes are applied only at an edge with no request presented; writes
// arriving while a request is presented are parked until then.
module sr_cfg_shadow
    import sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [NCORE-1:0] cfg_wdata,
    input  logic             busy,
    output sec_mode_t        mode,
    output logic             cfg_err
);
    logic             pend_q;
    logic [NCORE-1:0] pend_val_q;
    logic [NCORE-1:0] nxt_word;

    // Newest write wins over a parked one.
    always_comb nxt_word = cfg_we ? cfg_wdata : pend_val_q;

    // Apply or park configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_OPEN;
            cfg_err    <= 1'b0;
            pend_q     <= 1'b0;
            pend_val_q <= '0;
        end else if (!busy) begin
            if (cfg_we || pend_q) begin
                mode    <= sec_mode_t'(nxt_word);
                cfg_err <= (sec_mode_t'(nxt_word) == MODE_FORBID);
            end
            pend_q <= 1'b0;
        end else if (cfg_we) begin
            pend_q     <= 1'b1;
            pend_val_q <= cfg_wdata;
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode)) else $error("config changed under request"); // R12
endmodule

// File: rtl/sr_policy.sv
// Combinational access policy: from mode, world and region, decides
// deny, pinned core, or shared (load-balanced) handling.
// Assumes req fields are only meaningful while a request is presented.
module sr_policy
    import sr_pkg::*;
(
    input  sec_mode_t          mode,
    input  logic               cfg_err,
    input  logic               is_reg,
    input  logic [CIDX_W-1:0]  reg_core,
    input  logic               world_sec,
    input  logic               region_sec,
    output verdict_t           verdict
);
    // Decision table per mode.
    always_comb begin
        verdict = '{deny: 1'b0, share: 1'b0, pin_core: '0};
        if (cfg_err || mode == MODE_FORBID) begin
            verdict.deny = 1'b1;
        end else if (is_reg) begin
            unique case (mode)
                MODE_SPLIT:  verdict.deny = !world_sec && (reg_core == CIDX_W'(1));
                MODE_ALLSEC: verdict.deny = !world_sec;
                default:     verdict.deny = 1'b0;
            endcase
        end else begin
            unique case (mode)
                MODE_SPLIT: begin
                    if (world_sec) verdict.pin_core = region_sec ? CIDX_W'(1) : CIDX_W'(0);
                    else           verdict.deny     = region_sec;
                end
                MODE_ALLSEC: begin
                    verdict.deny  = !world_sec || !region_sec;
                    verdict.share = world_sec && region_sec;
                end
                default: verdict.share = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sr_core_pick.sv
// Picks a free core for shared requests with a rotating tie preference.
// Assumes 'advance' is raised only in a cycle where a shared grant is made.
module sr_core_pick
    import sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORE-1:0]  core_free,
    input  logic              advance,
    output logic              pick_valid,
    output logic [CIDX_W-1:0] pick_core
);
    logic [CIDX_W-1:0] pref_q;

    // Choose the preferred core on a tie, otherwise the single free one.
    always_comb begin
        pick_valid = |core_free;
        pick_core  = (&core_free) ? pref_q : (core_free[1] ? CIDX_W'(1) : CIDX_W'(0));
    end

    // Move preference away from the core just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)       pref_q <= '0;
        else if (advance) pref_q <= ~pick_core;
    end

    AST_PICK_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> core_free[pick_core]) else $error("picked busy core"); // R9
endmodule

// File: rtl/sec_router.sv
// Top of the dual-engine security access router. Accepts or denies each
// request, dispatches accepted memory requests to a core via start pulses
// gated by core_free, and selects register interfaces.
// Assumes the requester holds its request fields stable while req_valid=1.
module sec_router
    import sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_wdata,
    input  logic             req_valid,
    input  logic             req_is_reg,
    input  logic             req_reg_core,
    input  logic             req_world_sec,
    input  logic             req_region_sec,
    output logic             req_ready,
    output logic             req_err,
    input  logic [1:0]       core_free,
    output logic [1:0]       core_start,
    output logic [1:0]       reg_sel,
    output logic             config_error
);
    sec_mode_t         mode;
    verdict_t          verdict;
    logic              pick_valid;
    logic [CIDX_W-1:0] pick_core;
    logic [CIDX_W-1:0] mem_target;
    logic              mem_go;
    logic              advance;

    sr_cfg_shadow u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .busy(req_valid), .mode(mode), .cfg_err(config_error)
    );

    sr_policy u_pol (
        .mode(mode), .cfg_err(config_error), .is_reg(req_is_reg),
        .reg_core(req_reg_core), .world_sec(req_world_sec),
        .region_sec(req_region_sec), .verdict(verdict)
    );

    sr_core_pick u_pick (
        .clk(clk), .rst_n(rst_n), .core_free(core_free), .advance(advance),
        .pick_valid(pick_valid), .pick_core(pick_core)
    );

    // Resolve the memory target and whether it can start now.
    always_comb begin
        mem_target = verdict.share ? pick_core  : verdict.pin_core;
        mem_go     = verdict.share ? pick_valid : core_free[verdict.pin_core];
        advance    = req_valid && !verdict.deny && !req_is_reg && verdict.share && pick_valid;
        req_ready  = req_valid && (verdict.deny || req_is_reg || mem_go);
        req_err    = req_valid && verdict.deny;
    end

    // Per-core dispatch and register-select strobes.
    for (genvar gi = 0; gi < NCORE; gi++) begin : g_core
        always_comb begin
            core_start[gi] = req_valid && !verdict.deny && !req_is_reg && mem_go
                             && (mem_target == CIDX_W'(gi));
            reg_sel[gi]    = req_valid && !verdict.deny && req_is_reg
                             && (req_reg_core == CIDX_W'(gi));
        end
        AST_START_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            core_start[gi] |-> core_free[gi]) else $error("start to busy core"); // R11
    end

    AST_DENY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (core_start == '0 && reg_sel == '0 && req_ready)) else $error("denied leaked"); // R10
    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_start)) else $error("multiple starts"); // R9
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (config_error && req_valid) |-> req_err) else $error("request passed in error state"); // R8
endmodule

// File: tb/sec_router_tb.sv
// Bench for sec_router: behavioural reference model compared each cycle.
module sec_router_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       req_valid = 1'b0, req_is_reg = 1'b0, req_reg_core = 1'b0;
    logic       req_world_sec = 1'b0, req_region_sec = 1'b0;
    logic [1:0] core_free = 2'b11;
    logic       req_ready, req_err, config_error;
    logic [1:0] core_start, reg_sel;

    int   n_checks = 0;
    int   n_errors = 0;
    string tag = "R1";

    // model state
    logic [1:0] m_word;
    logic       m_err;
    logic       m_pend;
    logic [1:0] m_pend_word;
    int         m_pref;

    // expected outputs for the current cycle
    logic       e_ready, e_err;
    logic [1:0] e_start, e_sel;
    int         e_core;
    bit         e_share;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_is_reg(req_is_reg), .req_reg_core(req_reg_core),
        .req_world_sec(req_world_sec), .req_region_sec(req_region_sec),
        .req_ready(req_ready), .req_err(req_err), .core_free(core_free),
        .core_start(core_start), .reg_sel(reg_sel), .config_error(config_error)
    );

    // Behavioural expectation from the requirement table.
    task automatic expect_now();
        bit deny;
        int target;
        bit go;
        e_ready = 0; e_err = 0; e_start = 0; e_sel = 0; e_share = 0; e_core = 0;
        if (!req_valid) return;
        deny = 0; target = -1;
        if (m_err || m_word == 2'b01) deny = 1;
        else if (req_is_reg) begin
            if (m_word == 2'b10 && !req_world_sec && req_reg_core) deny = 1;
            if (m_word == 2'b11 && !req_world_sec) deny = 1;
        end else begin
            if (m_word == 2'b10) begin
                if (!req_world_sec && req_region_sec) deny = 1;
                else target = (req_world_sec && req_region_sec) ? 1 : 0;
            end else if (m_word == 2'b11) begin
                if (!(req_world_sec && req_region_sec)) deny = 1;
                else e_share = 1;
            end else e_share = 1;
        end
        if (deny) begin e_ready = 1; e_err = 1; return; end
        if (req_is_reg) begin
            e_ready = 1; e_sel[req_reg_core] = 1'b1; return;
        end
        if (e_share) begin
            if (core_free == 2'b11) target = m_pref;
            else if (core_free == 2'b10) target = 1;
            else if (core_free == 2'b01) target = 0;
            else target = -1;
            go = (target >= 0);
        end else go = core_free[target];
        if (go) begin e_ready = 1; e_start[target] = 1'b1; e_core = target; end
    endtask

    task automatic check1(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: compare at negedge, then advance the model at posedge.
    task automatic cyc();
        @(negedge clk);
        expect_now();
        if (rst_n) begin
            check1("req_ready", req_ready, e_ready);
            check1("req_err", req_err, e_err);
            check1("core_start", core_start, e_start);
            check1("reg_sel", reg_sel, e_sel);
            check1("config_error", config_error, m_err);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_word = 2'b00; m_err = 0; m_pend = 0; m_pend_word = 0; m_pref = 0;
        end else begin
            if (e_share && e_ready && !e_err) m_pref = 1 - e_core;
            if (!req_valid) begin
                if (cfg_we) begin m_word = cfg_wdata; m_err = (cfg_wdata == 2'b01); end
                else if (m_pend) begin m_word = m_pend_word; m_err = (m_pend_word == 2'b01); end
                m_pend = 0;
            end else if (cfg_we) begin
                m_pend = 1; m_pend_word = cfg_wdata;
            end
        end
        #1;
    endtask

    task automatic set_cfg(logic [1:0] w);
        cfg_we = 1; cfg_wdata = w;
        cyc();
        cfg_we = 0;
    endtask

    // Present one request until handshake (or limit), optional core release.
    task automatic send(bit is_reg, bit rc, bit ws, bit rs,
                        logic [1:0] free0, int hold, logic [1:0] free1);
        req_valid = 1; req_is_reg = is_reg; req_reg_core = rc;
        req_world_sec = ws; req_region_sec = rs; core_free = free0;
        for (int k = 0; k < 20; k++) begin
            if (k == hold) core_free = free1;
            cyc();
            if (e_ready) break;
        end
        req_valid = 0; core_free = 2'b11;
        cyc();
    endtask

    initial begin
        m_word = 0; m_err = 0; m_pend = 0; m_pend_word = 0; m_pref = 0;
        repeat (3) cyc();
        rst_n = 1;
        tag = "R1"; cyc();
        check1("reset config_error R1", config_error, 0);
        send(0, 0, 0, 0, 2'b11, 99, 2'b11);          // first tie goes core 0

        tag = "R7";
        send(1, 1, 0, 0, 2'b11, 99, 2'b11);
        send(1, 0, 1, 1, 2'b11, 99, 2'b11);
        send(0, 0, 1, 1, 2'b11, 99, 2'b11);
        tag = "R9";
        send(0, 0, 0, 1, 2'b11, 99, 2'b11);
        send(0, 0, 1, 0, 2'b01, 99, 2'b01);
        send(0, 0, 1, 0, 2'b10, 99, 2'b10);
        send(0, 0, 0, 0, 2'b00, 3, 2'b11);           // wait then tie

        tag = "R2"; set_cfg(2'b10);
        send(1, 1, 0, 0, 2'b11, 99, 2'b11);
        send(1, 0, 0, 0, 2'b11, 99, 2'b11);
        send(1, 1, 1, 0, 2'b11, 99, 2'b11);
        tag = "R3";
        send(0, 0, 0, 0, 2'b11, 99, 2'b11);
        send(0, 0, 0, 1, 2'b11, 99, 2'b11);
        tag = "R4";
        send(0, 0, 1, 1, 2'b11, 99, 2'b11);
        send(0, 0, 1, 0, 2'b11, 99, 2'b11);
        tag = "R11";
        send(0, 0, 1, 1, 2'b01, 4, 2'b10);           // pinned to core 1, waits
        send(0, 0, 0, 0, 2'b10, 2, 2'b01);           // pinned to core 0, waits

        tag = "R12";                                 // write while waiting
        req_valid = 1; req_is_reg = 0; req_world_sec = 0; req_region_sec = 0;
        core_free = 2'b00;
        cyc(); cfg_we = 1; cfg_wdata = 2'b01; cyc(); cfg_we = 0;
        cfg_we = 1; cfg_wdata = 2'b11; cyc(); cfg_we = 0;
        cyc(); core_free = 2'b01; cyc();
        req_valid = 0; core_free = 2'b11; cyc();
        send(1, 0, 0, 0, 2'b11, 99, 2'b11);          // all-secure now: denied

        tag = "R5";
        send(1, 1, 0, 0, 2'b11, 99, 2'b11);
        send(0, 0, 0, 1, 2'b11, 99, 2'b11);
        send(1, 1, 1, 0, 2'b11, 99, 2'b11);
        tag = "R6";
        send(0, 0, 1, 1, 2'b11, 99, 2'b11);
        send(0, 0, 1, 1, 2'b11, 99, 2'b11);
        send(0, 0, 1, 0, 2'b11, 99, 2'b11);
        send(0, 0, 1, 1, 2'b00, 2, 2'b10);

        tag = "R8"; set_cfg(2'b01);
        check1("config_error set R8", config_error, 1);
        send(1, 0, 1, 0, 2'b11, 99, 2'b11);
        send(0, 0, 1, 1, 2'b11, 99, 2'b11);
        tag = "R10";
        send(0, 0, 0, 0, 2'b11, 99, 2'b11);
        tag = "R8"; set_cfg(2'b00);
        check1("config_error cleared R8", config_error, 0);
        send(0, 0, 0, 0, 2'b11, 99, 2'b11);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule